// File: doc/BRIEF.md
# Descriptor-Driven Channel Sequencer

This block sits between a register bus and a co-processor engine that has several job channels. Software stores the address of a job descriptor in a channel's command pointer and then raises that channel's semaphore. The block picks one ready channel at a time and reads the eight-word descriptor through a memory read port. It checks the two control words and then either hands the job to an execution stage or ends the job at once with an error code. When the job ends, the block updates that channel's status, semaphore and command pointer and may raise an interrupt flag.

The execution stage is a stub that completes after a fixed number of cycles. A descriptor chains to the next one through its first word. The channel keeps following the chain while its semaphore stays nonzero. A zero link ends the chain and parks the channel.

The sequencer moves through six states:
- `S_IDLE`: arbitrate. A grant moves to `S_FETCH_REQ`.
- `S_FETCH_REQ`: present a word address. A handshake moves to `S_FETCH_WAIT`. An address in the protected region moves to `S_FINISH` with an error.
- `S_FETCH_WAIT`: take the response. It returns to `S_FETCH_REQ` for the next word, or goes to `S_DECODE` after the eighth word.
- `S_DECODE`: a valid job moves to `S_EXEC`. A rejected job moves to `S_FINISH`.
- `S_EXEC`: the stub's done pulse moves to `S_FINISH`.
- `S_FINISH`: write back the results and return to `S_IDLE`.

Top module: `dsc_ctrl`

## Requirements
- R1: After reset the capability word at 0x040 reads 0x00050001 (bit 0 AES-128, bit 16 SHA-1, bit 18 SHA-256). Global status (0x010), channel enables (0x020), and every channel's semaphore and status read 0.
- R2: A write to a channel's semaphore (0x110 + n·0x40) adds the low SEMA_W bits of the write data, saturating at all ones. The add happens only when bit n of the enable register at 0x020 is 1. A disabled channel's semaphore stays unchanged and no fetch is made.
- R3: A channel is ready when it is enabled, its semaphore is nonzero and its command pointer (0x100 + n·0x40) is nonzero. For each job the block reads exactly eight words at pointer + 4·k, k = 0..7. Each request holds its valid and address until ready is seen.
- R4: A job that passes decode pulses `exec_start` for one cycle with `exec_chan` naming the channel. The job completes EXEC_LAT cycles later.
- R5: When a job completes, control word bit 1 (descriptor word 1) decrements the semaphore. Control word bit 0 sets global status bit n. With both bits clear, neither the semaphore nor the flag changes.
- R6: On completion without error, the command pointer takes word 0 of the descriptor. A nonzero link with a nonzero semaphore fetches the next descriptor. A zero link parks the channel. A link reached when the semaphore is zero waits for the next semaphore write.
- R7: A cipher job (word 1 bit 5) whose size word (word 5) is not a multiple of 16 ends with status code 2 and sets its interrupt flag. It never reaches the execution stage.
- R8: No request is issued to an address at or above 0xFFFF0000. Reaching such a word ends the job with status code 1 and sets the interrupt flag. Earlier words of the same descriptor are still read.
- R9: A job ends with status code 3 without execution when either of these holds: it enables hashing (word 1 bit 6) with word 2 bits 19:16 other than 0 (SHA-1) or 2 (SHA-256), or it enables the cipher with word 2 bits 3:0 other than 0 (AES-128). This check takes priority over the size check.
- R10: Writing ones to 0x018 clears those global flags. Writing ones to a channel's 0x128 + n·0x40 clears those status bits. `irq` is high while any global flag is set.
- R11: Any error clears the channel's semaphore and leaves its command pointer unchanged. The channel status code (bits 3:0) holds the result of the latest job: 0 for success.
- R12: Ready channels are served one descriptor at a time, in rotating order starting after the channel served last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_rd_valid | output | 1 | Descriptor word request valid |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rd_addr | output | 32 | Descriptor word byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| exec_start | output | 1 | One-cycle job hand-off pulse |
| exec_chan | output | 2 | Channel of the job being handed off |
| irq | output | 1 | OR of the global interrupt flags |

## Verification
The bench builds the block with four channels, a 3-cycle execution stub and a 4-bit semaphore. The short stub keeps six back-to-back jobs within a short run, so the rotating order across three ready channels can be observed. The 4-bit semaphore makes saturation reachable with two writes. A mode in which the memory alternates ready low and high exercises the request hold rule during a two-descriptor chain. Pointers just below the protected region show that words before the boundary are still fetched.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_REQ,
        S_FETCH_WAIT,
        S_DECODE,
        S_EXEC,
        S_FINISH
    } dsc_state_e;

    localparam int DESC_WORDS = 8;
    localparam int W_LINK     = 0;
    localparam int W_CTRL0    = 1;
    localparam int W_CTRL1    = 2;
    localparam int W_SIZE     = 5;

    localparam logic [3:0] ERR_NONE = 4'd0;
    localparam logic [3:0] ERR_ADDR = 4'd1;
    localparam logic [3:0] ERR_SIZE = 4'd2;
    localparam logic [3:0] ERR_ALG  = 4'd3;

    localparam int C0_IRQ    = 0;
    localparam int C0_DEC    = 1;
    localparam int C0_CIPHER = 5;
    localparam int C0_HASH   = 6;

    localparam logic [3:0] HSEL_SHA1   = 4'd0;
    localparam logic [3:0] HSEL_SHA256 = 4'd2;
    localparam logic [3:0] CSEL_AES128 = 4'd0;

    localparam logic [31:0] CAP_VALUE = 32'h0005_0001;

    localparam logic [11:0] A_CTRL     = 12'h000;
    localparam logic [11:0] A_GSTAT    = 12'h010;
    localparam logic [11:0] A_GSTAT_CL = 12'h018;
    localparam logic [11:0] A_CHEN     = 12'h020;
    localparam logic [11:0] A_CAP      = 12'h040;
    localparam logic [11:0] A_CTXPTR   = 12'h050;

    localparam logic [3:0] PAGE_GLOBAL = 4'h0;
    localparam logic [3:0] PAGE_CHAN   = 4'h1;
    localparam logic [5:0] O_PTR       = 6'h00;
    localparam logic [5:0] O_SEMA      = 6'h10;
    localparam logic [5:0] O_STAT      = 6'h20;
    localparam logic [5:0] O_STAT_CL   = 6'h28;

endpackage

// File: rtl/dsc_chan.sv
module dsc_chan
    import dsc_pkg::*;
#(
    parameter int SEMA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ptr_we,
    input  logic              sema_we,
    input  logic              stat_cl_we,
    input  logic [31:0]       wdata,
    input  logic              fin,
    input  logic [3:0]        fin_err,
    input  logic              fin_dec,
    input  logic [31:0]       fin_link,
    output logic [31:0]       cmd_ptr,
    output logic [SEMA_W-1:0] sema,
    output logic [3:0]        stat_code,
    output logic              ready
);

    localparam logic [SEMA_W:0] SEMA_MAX = {1'b0, {SEMA_W{1'b1}}};

    logic [SEMA_W-1:0] add_val;
    logic [SEMA_W:0]   sum;
    logic [SEMA_W-1:0] sema_nxt;
    logic              fin_ok;

    assign fin_ok = fin && (fin_err == ERR_NONE);

    always_comb begin
        add_val = (sema_we && enable) ? wdata[SEMA_W-1:0] : '0;
        sum     = {1'b0, sema} + {1'b0, add_val};
        if (fin_ok && fin_dec && (sum != '0)) begin
            sum = sum - 1'b1;
        end
        sema_nxt = (sum > SEMA_MAX) ? SEMA_MAX[SEMA_W-1:0] : sum[SEMA_W-1:0];
        if (fin && !fin_ok) begin
            sema_nxt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_ptr   <= '0;
            sema      <= '0;
            stat_code <= ERR_NONE;
        end else begin
            sema <= sema_nxt;
            if (ptr_we) begin
                cmd_ptr <= wdata;
            end else if (fin_ok) begin
                cmd_ptr <= fin_link;
            end
            if (fin) begin
                stat_code <= fin_err;
            end else if (stat_cl_we) begin
                stat_code <= stat_code & ~wdata[3:0];
            end
        end
    end

    assign ready = enable && (sema != '0) && (cmd_ptr != '0);

endmodule

// File: rtl/dsc_rr_arb.sv
module dsc_rr_arb #(
    parameter int N = 4
)(
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] last,
    output logic                 gnt_any,
    output logic [$clog2(N)-1:0] gnt_idx
);

    localparam int IDX_W = $clog2(N);

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            if (!gnt_any && req[(int'(last) + k) % N]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'((int'(last) + k) % N);
            end
        end
    end

endmodule

// File: rtl/dsc_exec_stub.sv
module dsc_exec_stub #(
    parameter int LAT = 6
)(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(LAT - 1);
        end else if (run) begin
            if (cnt == '0) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = run && (cnt == '0);

endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
    import dsc_pkg::*;
#(
    parameter int          NUM_CH   = 4,
    parameter int          SEMA_W   = 8,
    parameter int          EXEC_LAT = 6,
    parameter logic [31:0] ROM_BASE = 32'hFFFF_0000
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [11:0]               reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      mem_rd_valid,
    input  logic                      mem_rd_ready,
    output logic [31:0]               mem_rd_addr,
    input  logic                      mem_rsp_valid,
    input  logic [31:0]               mem_rsp_data,
    output logic                      exec_start,
    output logic [$clog2(NUM_CH)-1:0] exec_chan,
    output logic                      irq
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int IDX_W = $clog2(DESC_WORDS);

    dsc_state_e state, state_nxt;

    logic [31:0]       ctrl_reg, ctx_ptr;
    logic [7:0]        chan_en;
    logic [NUM_CH-1:0] flags, flag_set, flag_clr;

    logic [31:0]       ch_ptr  [NUM_CH];
    logic [SEMA_W-1:0] ch_sema [NUM_CH];
    logic [3:0]        ch_stat [NUM_CH];
    logic [NUM_CH-1:0] ch_ready;

    logic [CH_W-1:0]   cur_ch, last_ch, gnt_idx;
    logic              gnt_any;
    logic [31:0]       job_ptr;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       d_link, d_c0, d_c1, d_size;
    logic [3:0]        job_err, dec_err;
    logic [31:0]       fetch_addr;
    logic              fetch_bad, exec_done, fin;

    logic              chan_page, glob_page;
    logic [CH_W-1:0]   page_ch;
    logic [5:0]        page_off;

    assign glob_page = (reg_addr[11:8] == PAGE_GLOBAL);
    assign chan_page = (reg_addr[11:8] == PAGE_CHAN) && (int'(reg_addr[7:6]) < NUM_CH);
    assign page_ch   = CH_W'(reg_addr[7:6]);
    assign page_off  = reg_addr[5:0];

    // global registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_reg <= '0;
            ctx_ptr  <= '0;
            chan_en  <= '0;
            flags    <= '0;
        end else begin
            if (reg_we && reg_addr == A_CTRL)   ctrl_reg <= reg_wdata;
            if (reg_we && reg_addr == A_CTXPTR) ctx_ptr  <= reg_wdata;
            if (reg_we && reg_addr == A_CHEN)   chan_en  <= reg_wdata[7:0];
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        flag_set = '0;
        if (fin && (job_err != ERR_NONE || d_c0[C0_IRQ])) begin
            flag_set[cur_ch] = 1'b1;
        end
        flag_clr = (reg_we && reg_addr == A_GSTAT_CL) ? reg_wdata[NUM_CH-1:0] : '0;
    end

    assign irq = |flags;

    // per-channel register sets
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        dsc_chan #(.SEMA_W(SEMA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (chan_en[n]),
            .ptr_we     (reg_we && chan_page && int'(page_ch) == n && page_off == O_PTR),
            .sema_we    (reg_we && chan_page && int'(page_ch) == n && page_off == O_SEMA),
            .stat_cl_we (reg_we && chan_page && int'(page_ch) == n && page_off == O_STAT_CL),
            .wdata      (reg_wdata),
            .fin        (fin && int'(cur_ch) == n),
            .fin_err    (job_err),
            .fin_dec    (d_c0[C0_DEC]),
            .fin_link   (d_link),
            .cmd_ptr    (ch_ptr[n]),
            .sema       (ch_sema[n]),
            .stat_code  (ch_stat[n]),
            .ready      (ch_ready[n])
        );
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (glob_page) begin
            case (reg_addr[7:0])
                A_CTRL[7:0]:   reg_rdata = ctrl_reg;
                A_GSTAT[7:0]:  reg_rdata = 32'(flags);
                A_CHEN[7:0]:   reg_rdata = {24'b0, chan_en};
                A_CAP[7:0]:    reg_rdata = CAP_VALUE;
                A_CTXPTR[7:0]: reg_rdata = ctx_ptr;
                default:       reg_rdata = '0;
            endcase
        end else if (chan_page) begin
            case (page_off)
                O_PTR:   reg_rdata = ch_ptr[page_ch];
                O_SEMA:  reg_rdata = 32'(ch_sema[page_ch]);
                O_STAT:  reg_rdata = 32'(ch_stat[page_ch]);
                default: reg_rdata = '0;
            endcase
        end
    end

    dsc_rr_arb #(.N(NUM_CH)) u_arb (
        .req     (ch_ready),
        .last    (last_ch),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    dsc_exec_stub #(.LAT(EXEC_LAT)) u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (exec_start),
        .done  (exec_done)
    );

    assign fetch_addr = job_ptr + (32'(idx) << 2);
    assign fetch_bad  = (fetch_addr >= ROM_BASE);

    // decode checks, algorithm before size
    always_comb begin
        dec_err = ERR_NONE;
        if ((d_c0[C0_HASH] && d_c1[19:16] != HSEL_SHA1 && d_c1[19:16] != HSEL_SHA256) ||
            (d_c0[C0_CIPHER] && d_c1[3:0] != CSEL_AES128)) begin
            dec_err = ERR_ALG;
        end else if (d_c0[C0_CIPHER] && d_size[3:0] != 4'd0) begin
            dec_err = ERR_SIZE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:       if (gnt_any) state_nxt = S_FETCH_REQ;
            S_FETCH_REQ:  if (fetch_bad) state_nxt = S_FINISH;
                          else if (mem_rd_ready) state_nxt = S_FETCH_WAIT;
            S_FETCH_WAIT: if (mem_rsp_valid) state_nxt = (idx == IDX_W'(DESC_WORDS - 1)) ? S_DECODE : S_FETCH_REQ;
            S_DECODE:     state_nxt = (dec_err != ERR_NONE) ? S_FINISH : S_EXEC;
            S_EXEC:       if (exec_done) state_nxt = S_FINISH;
            S_FINISH:     state_nxt = S_IDLE;
            default:      state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_valid = (state == S_FETCH_REQ) && !fetch_bad;
        mem_rd_addr  = fetch_addr;
        exec_start   = (state == S_DECODE) && (dec_err == ERR_NONE);
        exec_chan    = cur_ch;
        fin          = (state == S_FINISH);
    end

    // job datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch  <= '0;
            last_ch <= CH_W'(NUM_CH - 1);
            job_ptr <= '0;
            idx     <= '0;
            job_err <= ERR_NONE;
            d_link  <= '0;
            d_c0    <= '0;
            d_c1    <= '0;
            d_size  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (gnt_any) begin
                    cur_ch  <= gnt_idx;
                    last_ch <= gnt_idx;
                    job_ptr <= ch_ptr[gnt_idx];
                    idx     <= '0;
                    job_err <= ERR_NONE;
                end
                S_FETCH_REQ: if (fetch_bad) job_err <= ERR_ADDR;
                S_FETCH_WAIT: if (mem_rsp_valid) begin
                    case (int'(idx))
                        W_LINK:  d_link <= mem_rsp_data;
                        W_CTRL0: d_c0   <= mem_rsp_data;
                        W_CTRL1: d_c1   <= mem_rsp_data;
                        W_SIZE:  d_size <= mem_rsp_data;
                        default: ;
                    endcase
                    idx <= idx + 1'b1;
                end
                S_DECODE: job_err <= dec_err;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dsc_ctrl_chk.sv
module dsc_ctrl_chk
    import dsc_pkg::*;
#(
    parameter logic [31:0] ROM_BASE = 32'hFFFF_0000
)(
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        exec_start,
    input logic        irq,
    input dsc_state_e  state
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R8
    rom_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr < ROM_BASE);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    // R4
    start_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> state == S_EXEC);

    // R5
    irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state) == S_FINISH);

endmodule

bind dsc_ctrl dsc_ctrl_chk #(.ROM_BASE(ROM_BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .exec_start   (exec_start),
    .irq          (irq),
    .state        (state)
);

// File: tb/tb_dsc_ctrl.sv
module tb_dsc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        exec_start;
    logic [1:0]  exec_chan;
    logic        irq;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] mem [256];
    int          exec_log [64];
    int          log_n = 0;
    int          req_n = 0;
    logic        stall_mode = 1'b0;

    dsc_ctrl #(.NUM_CH(NUM_CH), .SEMA_W(4), .EXEC_LAT(3)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .exec_start(exec_start),
        .exec_chan(exec_chan), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model and event logger
    always @(posedge clk) begin
        if (mem_rd_valid && mem_rd_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_rd_addr[9:2]];
            req_n         <= req_n + 1;
        end else begin
            mem_rsp_valid <= 1'b0;
        end
        mem_rd_ready <= stall_mode ? ~mem_rd_ready : 1'b1;
        if (exec_start && log_n < 64) begin
            exec_log[log_n] <= int'(exec_chan);
            log_n           <= log_n + 1;
        end
    end

    function automatic logic [11:0] ch_a(input int n, input logic [5:0] off);
        return 12'h100 + 12'(n * 'h40) + 12'(off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_desc(input int a, input logic [31:0] link, c0, c1, size);
        for (int k = 0; k < 8; k++) mem[(a >> 2) + k] = 32'h0;
        mem[(a >> 2) + 0] = link;
        mem[(a >> 2) + 1] = c0;
        mem[(a >> 2) + 2] = c1;
        mem[(a >> 2) + 5] = size;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h040, v); chk("R1 capability", v, 32'h0005_0001);
        rd(12'h010, v); chk("R1 global status", v, 0);
        rd(12'h020, v); chk("R1 enables", v, 0);
        rd(ch_a(0, 6'h10), v); chk("R1 ch0 semaphore", v, 0);
        rd(ch_a(3, 6'h20), v); chk("R1 ch3 status", v, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int r0 = req_n;
        put_desc('h040, 0, 32'h3043, 32'h0002_0000, 64);
        wr(ch_a(2, 6'h00), 32'h40);
        wr(ch_a(2, 6'h10), 1);
        run(20);
        rd(ch_a(2, 6'h10), v); chk("R2 disabled semaphore", v, 0);
        chk("R2 disabled no fetch", 32'(req_n - r0), 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int r0 = req_n, l0 = log_n;
        wr(ch_a(0, 6'h00), 32'h40);
        wr(ch_a(0, 6'h10), 1);
        run(60);
        chk("R3 eight word reads", 32'(req_n - r0), 8);
        chk("R4 one hand-off", 32'(log_n - l0), 1);
        chk("R4 hand-off channel", 32'(exec_log[l0]), 0);
        rd(ch_a(0, 6'h10), v); chk("R5 semaphore decremented", v, 0);
        rd(12'h010, v); chk("R5 flag bit0", v, 1);
        chk("R10 irq high", 32'(irq), 1);
        rd(ch_a(0, 6'h00), v); chk("R6 zero link parks", v, 0);
        rd(ch_a(0, 6'h20), v); chk("R11 success code", v, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(12'h018, 32'h1);
        rd(12'h010, v); chk("R10 global clear", v, 0);
        chk("R10 irq low", 32'(irq), 0);
    endtask

    task automatic t_chain_stall();
        logic [31:0] v;
        int r0 = req_n, l0 = log_n;
        put_desc('h080, 32'hC0, 32'h0B23, 32'h10, 32);
        put_desc('h0C0, 0, 32'h0023, 0, 16);
        stall_mode = 1'b1;
        wr(ch_a(1, 6'h00), 32'h80);
        wr(ch_a(1, 6'h10), 2);
        run(150);
        stall_mode = 1'b0;
        chk("R6 two chained jobs", 32'(log_n - l0), 2);
        chk("R6 job0 channel", 32'(exec_log[l0]), 1);
        chk("R6 job1 channel", 32'(exec_log[l0 + 1]), 1);
        chk("R3 reads under stall", 32'(req_n - r0), 16);
        rd(ch_a(1, 6'h10), v); chk("R5 chain semaphore", v, 0);
        rd(12'h010, v); chk("R5 flag bit1", v, 2);
        wr(12'h018, 32'hF);
    endtask

    task automatic t_chain_parked();
        logic [31:0] v;
        int l0 = log_n;
        wr(ch_a(1, 6'h00), 32'h80);
        wr(ch_a(1, 6'h10), 1);
        run(60);
        chk("R6 stops at zero semaphore", 32'(log_n - l0), 1);
        rd(ch_a(1, 6'h00), v); chk("R6 pointer parked on link", v, 32'hC0);
        wr(ch_a(1, 6'h10), 1);
        run(60);
        chk("R6 resumes on semaphore", 32'(log_n - l0), 2);
        rd(ch_a(1, 6'h00), v); chk("R6 chain end pointer", v, 0);
        wr(12'h018, 32'hF);
    endtask

    task automatic t_quiet_job();
        logic [31:0] v;
        int l0 = log_n;
        put_desc('h180, 0, 32'h0040, 0, 0);
        wr(ch_a(0, 6'h00), 32'h180);
        wr(ch_a(0, 6'h10), 1);
        run(60);
        chk("R5 quiet job ran", 32'(log_n - l0), 1);
        rd(ch_a(0, 6'h10), v); chk("R5 no decrement", v, 1);
        rd(12'h010, v); chk("R5 no flag", v, 0);
        chk("R5 irq stays low", 32'(irq), 0);
    endtask

    task automatic t_size_err();
        logic [31:0] v;
        int l0 = log_n;
        put_desc('h1C0, 32'h80, 32'h0023, 0, 20);
        wr(ch_a(1, 6'h00), 32'h1C0);
        wr(ch_a(1, 6'h10), 2);
        run(60);
        chk("R7 no hand-off", 32'(log_n - l0), 0);
        rd(ch_a(1, 6'h20), v); chk("R7 size code", v, 2);
        rd(12'h010, v); chk("R7 flag", v, 2);
        rd(ch_a(1, 6'h10), v); chk("R11 semaphore cleared", v, 0);
        rd(ch_a(1, 6'h00), v); chk("R11 pointer kept", v, 32'h1C0);
        wr(ch_a(1, 6'h28), 32'hF);
        rd(ch_a(1, 6'h20), v); chk("R10 channel status clear", v, 0);
        wr(12'h018, 32'hF);
    endtask

    task automatic t_round_robin();
        logic [31:0] v;
        int l0 = log_n;
        int exp_ch [6] = '{0, 1, 3, 0, 1, 3};
        put_desc('h100, 32'h140, 32'h0043, 32'h0002_0000, 64);
        put_desc('h140, 0, 32'h0043, 0, 0);
        wr(ch_a(1, 6'h00), 32'h100);
        wr(ch_a(3, 6'h00), 32'h100);
        wr(ch_a(0, 6'h00), 32'h100);
        wr(ch_a(1, 6'h10), 2);
        wr(ch_a(3, 6'h10), 2);
        wr(ch_a(0, 6'h10), 1);
        run(300);
        chk("R12 job count", 32'(log_n - l0), 6);
        for (int k = 0; k < 6; k++) chk("R12 service order", 32'(exec_log[l0 + k]), 32'(exp_ch[k]));
        rd(12'h010, v); chk("R12 flags", v, 32'hB);
        rd(ch_a(3, 6'h10), v); chk("R12 ch3 semaphore", v, 0);
        wr(12'h018, 32'hF);
    endtask

    task automatic t_rom();
        logic [31:0] v;
        int r0 = req_n, l0 = log_n;
        wr(ch_a(0, 6'h00), 32'hFFFF_0000);
        wr(ch_a(0, 6'h10), 2);
        run(20);
        chk("R8 no request in region", 32'(req_n - r0), 0);
        chk("R8 no hand-off", 32'(log_n - l0), 0);
        rd(ch_a(0, 6'h20), v); chk("R8 address code", v, 1);
        rd(ch_a(0, 6'h10), v); chk("R11 semaphore cleared", v, 0);
        rd(12'h010, v); chk("R8 flag", v, 1);
        r0 = req_n;
        wr(ch_a(0, 6'h00), 32'hFFFE_FFF8);
        wr(ch_a(0, 6'h10), 1);
        run(30);
        chk("R8 words below boundary read", 32'(req_n - r0), 2);
        rd(ch_a(0, 6'h20), v); chk("R8 boundary code", v, 1);
        wr(12'h018, 32'hF);
    endtask

    task automatic t_alg_err();
        logic [31:0] v;
        int l0 = log_n;
        put_desc('h200, 0, 32'h0023, 32'h0000_0001, 20);
        wr(ch_a(1, 6'h00), 32'h200);
        wr(ch_a(1, 6'h10), 1);
        run(60);
        chk("R9 no hand-off", 32'(log_n - l0), 0);
        rd(ch_a(1, 6'h20), v); chk("R9 algorithm code over size", v, 3);
        put_desc('h240, 0, 32'h0043, 32'h0001_0000, 64);
        wr(ch_a(1, 6'h00), 32'h240);
        wr(ch_a(1, 6'h10), 1);
        run(60);
        rd(ch_a(1, 6'h20), v); chk("R9 hash select code", v, 3);
        rd(12'h010, v); chk("R9 flag", v, 2);
    endtask

    task automatic t_saturate();
        logic [31:0] v;
        wr(ch_a(3, 6'h10), 12);
        rd(ch_a(3, 6'h10), v); chk("R2 semaphore add", v, 12);
        wr(ch_a(3, 6'h10), 9);
        rd(ch_a(3, 6'h10), v); chk("R2 semaphore saturates", v, 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
        run(3);
        rst_n = 1'b1;
        run(2);
        t_reset();
        wr(12'h020, 32'h0B);
        t_disabled();
        t_single();
        t_clear();
        t_chain_stall();
        t_chain_parked();
        t_quiet_job();
        t_size_err();
        t_round_robin();
        t_rom();
        t_alg_err();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule